// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block sits between a command source and a single DRAM bank that shares one bidirectional data bus. Each cycle the source may present one request: activate a row, read, write or precharge. The guard grants the request in the same cycle only when the bank is in a state that accepts the command and every timing window that applies to it has run out. When a request is held back, a reason code names the first constraint that blocks it. This makes stalls easy to trace.

Timing values are written through a configuration port, normally once right after reset while the bank is idle. Each window is tracked by a down-counter that is loaded when the command that opens the window is granted. The counter stops at zero. The spacing between activates is the larger of the programmed row cycle and the sum of the minimum active time and the precharge time. A write that follows a read also waits for the read data to leave the bus and then for a programmed turnaround gap.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset the bank is idle (`bank_open_o`=0) and all timing windows are clear, so an activate request is granted on the first cycle after the configuration load.
- R2: Read, write and precharge requests are refused with reason 1 (state) while the bank is idle, and an activate request is refused with reason 1 while a row is open. A granted activate opens the row and a granted precharge closes it.
- R3: A read or write is not granted earlier than tRCD cycles after the granted activate (reason 2). With tRCD of 0 or 1 it may be granted on the next cycle.
- R4: A precharge is not granted earlier than tRAS cycles after the granted activate (reason 3).
- R5: An activate is not granted earlier than tRP cycles after the granted precharge (reason 4).
- R6: An activate is not granted earlier than max(tRC, tRAS+tRP) cycles after the previous granted activate (reason 5), even when the programmed tRC is smaller.
- R7: If a read is granted at cycle t, its data occupies the bus at cycle t+tCL, and a write is not granted before cycle t+tCL+1+tRWT (reason 6).
- R8: `grant_o` depends combinationally on the request and the current state. It is high only when `req_valid_i` is high, at most one command is granted per cycle, and the reason is 0 whenever the request is granted or no request is present.
- R9: Command encoding: 0 activate, 1 read, 2 write, 3 precharge. When several constraints block a request, the reason follows this priority: state, then tRP before tRC for an activate, and tRCD before the turnaround for a write.
- R10: Values presented while `cfg_load_i` is high are captured at that clock edge and apply to all later grants. A value of 0 imposes no wait beyond the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Capture the timing values |
| cfg_trcd_i | input | TW | Activate to read/write delay |
| cfg_tras_i | input | TW | Minimum activate to precharge time |
| cfg_trp_i | input | TW | Precharge to activate delay |
| cfg_trc_i | input | TW | Programmed activate to activate spacing |
| cfg_tcl_i | input | TW | Read command to read data latency |
| cfg_trwt_i | input | TW | Read to write bus turnaround gap |
| req_valid_i | input | 1 | A command request is present |
| req_cmd_i | input | 2 | Command: 0 activate, 1 read, 2 write, 3 precharge |
| grant_o | output | 1 | The request issues this cycle |
| block_reason_o | output | 3 | 0 none, 1 state, 2 tRCD, 3 tRAS, 4 tRP, 5 tRC, 6 turnaround |
| bank_open_o | output | 1 | A row is open |

## Verification
Each configuration in a sweep is first run with a greedy loop. The loop asks for activate, read, write and precharge in turn and retries each one until it is granted. This places every grant at the earliest legal cycle, so a window that ends one cycle too early or too late shows up. The sweep includes configurations where tRC is larger than tRAS+tRP and configurations where it is smaller, which tells whether the larger of the two governs activate spacing. A pseudo-random burst of commands with idle gaps then exercises illegal-state requests and the reason priorities, and an all-zero configuration checks back-to-back issue.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_STATE = 3'd1,
    RSN_TRCD  = 3'd2,
    RSN_TRAS  = 3'd3,
    RSN_TRP   = 3'd4,
    RSN_TRC   = 3'd5,
    RSN_TRWT  = 3'd6
  } reason_e;

  localparam int unsigned NUM_WIN = 5;
  localparam int unsigned WIN_RCD = 0;
  localparam int unsigned WIN_RAS = 1;
  localparam int unsigned WIN_RP  = 2;
  localparam int unsigned WIN_RC  = 3;
  localparam int unsigned WIN_RWT = 4;
endpackage

// File: rtl/dcg_cfg_regs.sv
module dcg_cfg_regs #(
  parameter int unsigned TW = 8,
  localparam int unsigned CW = TW + 1,
  localparam int unsigned NW = dcg_pkg::NUM_WIN
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [TW-1:0]          trcd_i,
  input  logic [TW-1:0]          tras_i,
  input  logic [TW-1:0]          trp_i,
  input  logic [TW-1:0]          trc_i,
  input  logic [TW-1:0]          tcl_i,
  input  logic [TW-1:0]          trwt_i,
  output logic [NW-1:0][CW-1:0]  ld_val_o
);
  import dcg_pkg::*;

  function automatic logic [CW-1:0] dec_sat(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [CW-1:0] ras_rp_sum, trc_w, rc_eff, rwt_span;
  logic [NW-1:0][CW-1:0] ld_d, ld_q;

  // effective row cycle folded into one value at load time
  assign ras_rp_sum = {1'b0, tras_i} + {1'b0, trp_i};
  assign trc_w      = {1'b0, trc_i};
  assign rc_eff     = (trc_w > ras_rp_sum) ? trc_w : ras_rp_sum;
  // bus busy through t+tCL, then tRWT gap: earliest write t+tCL+1+tRWT
  assign rwt_span   = {1'b0, tcl_i} + {1'b0, trwt_i};

  always_comb begin
    ld_d[WIN_RCD] = dec_sat({1'b0, trcd_i});
    ld_d[WIN_RAS] = dec_sat({1'b0, tras_i});
    ld_d[WIN_RP]  = dec_sat({1'b0, trp_i});
    ld_d[WIN_RC]  = dec_sat(rc_eff);
    ld_d[WIN_RWT] = rwt_span;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ld_q <= '0;
    else if (load_i) ld_q <= ld_d;
  end

  assign ld_val_o = ld_q;

  assert_rc_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ld_q[WIN_RC] >= ld_q[WIN_RAS]) && (ld_q[WIN_RC] >= ld_q[WIN_RP]));
endmodule

// File: rtl/dcg_down_counter.sv
module dcg_down_counter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_cnt_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zero_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_cnt_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));
endmodule

// File: rtl/dcg_bank_state.sv
module dcg_bank_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pre_i,
  output logic open_o
);
  typedef enum logic {BANK_IDLE = 1'b0, BANK_OPEN = 1'b1} bank_e;
  bank_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= BANK_IDLE;
    else if (act_i) st_q <= BANK_OPEN;
    else if (pre_i) st_q <= BANK_IDLE;
  end

  assign open_o = (st_q == BANK_OPEN);

  assert_act_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o);
  assert_pre_closes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> !open_o);
  assert_one_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_i && pre_i));
endmodule

// File: rtl/dcg_issue_check.sv
module dcg_issue_check
  import dcg_pkg::*;
(
  input  logic               req_valid_i,
  input  cmd_e               req_cmd_i,
  input  logic               open_i,
  input  logic [NUM_WIN-1:0] win_zero_i,
  output logic               grant_o,
  output reason_e            reason_o
);
  always_comb begin
    grant_o  = 1'b0;
    reason_o = RSN_NONE;
    if (req_valid_i) begin
      unique case (req_cmd_i)
        CMD_ACT: begin
          if (open_i)                  reason_o = RSN_STATE;
          else if (!win_zero_i[WIN_RP]) reason_o = RSN_TRP;
          else if (!win_zero_i[WIN_RC]) reason_o = RSN_TRC;
          else                         grant_o  = 1'b1;
        end
        CMD_RD: begin
          if (!open_i)                  reason_o = RSN_STATE;
          else if (!win_zero_i[WIN_RCD]) reason_o = RSN_TRCD;
          else                          grant_o  = 1'b1;
        end
        CMD_WR: begin
          if (!open_i)                  reason_o = RSN_STATE;
          else if (!win_zero_i[WIN_RCD]) reason_o = RSN_TRCD;
          else if (!win_zero_i[WIN_RWT]) reason_o = RSN_TRWT;
          else                          grant_o  = 1'b1;
        end
        default: begin
          if (!open_i)                  reason_o = RSN_STATE;
          else if (!win_zero_i[WIN_RAS]) reason_o = RSN_TRAS;
          else                          grant_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard #(
  parameter int unsigned TW = 8,
  localparam int unsigned CW = TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_load_i,
  input  logic [TW-1:0] cfg_trcd_i,
  input  logic [TW-1:0] cfg_tras_i,
  input  logic [TW-1:0] cfg_trp_i,
  input  logic [TW-1:0] cfg_trc_i,
  input  logic [TW-1:0] cfg_tcl_i,
  input  logic [TW-1:0] cfg_trwt_i,
  input  logic          req_valid_i,
  input  logic [1:0]    req_cmd_i,
  output logic          grant_o,
  output logic [2:0]    block_reason_o,
  output logic          bank_open_o
);
  import dcg_pkg::*;

  logic [NUM_WIN-1:0][CW-1:0] ld_val;
  logic [NUM_WIN-1:0]         win_load, win_zero;
  logic                       open, grant;
  logic                       g_act, g_rd, g_wr, g_pre;
  cmd_e                       cmd;
  reason_e                    reason;

  assign cmd = cmd_e'(req_cmd_i);

  dcg_cfg_regs #(.TW(TW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load_i),
    .trcd_i  (cfg_trcd_i),
    .tras_i  (cfg_tras_i),
    .trp_i   (cfg_trp_i),
    .trc_i   (cfg_trc_i),
    .tcl_i   (cfg_tcl_i),
    .trwt_i  (cfg_trwt_i),
    .ld_val_o(ld_val)
  );

  dcg_issue_check u_chk (
    .req_valid_i(req_valid_i),
    .req_cmd_i  (cmd),
    .open_i     (open),
    .win_zero_i (win_zero),
    .grant_o    (grant),
    .reason_o   (reason)
  );

  assign g_act = grant && (cmd == CMD_ACT);
  assign g_rd  = grant && (cmd == CMD_RD);
  assign g_wr  = grant && (cmd == CMD_WR);
  assign g_pre = grant && (cmd == CMD_PRE);

  always_comb begin
    win_load          = '0;
    win_load[WIN_RCD] = g_act;
    win_load[WIN_RAS] = g_act;
    win_load[WIN_RC]  = g_act;
    win_load[WIN_RP]  = g_pre;
    win_load[WIN_RWT] = g_rd;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    dcg_down_counter #(.CW(CW)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(win_load[w]),
      .val_i (ld_val[w]),
      .zero_o(win_zero[w])
    );
  end

  dcg_bank_state u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (g_act),
    .pre_i (g_pre),
    .open_o(open)
  );

  assign grant_o        = grant;
  assign block_reason_o = reason;
  assign bank_open_o    = open;

  assert_grant_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> req_valid_i);
  assert_grant_no_reason_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (block_reason_o == 3'd0));
  assert_block_has_reason_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !grant_o) |-> (block_reason_o != 3'd0));
  assert_col_needs_row_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && (req_cmd_i != 2'd0)) |-> bank_open_o);
  assert_act_needs_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && (req_cmd_i == 2'd0)) |-> !bank_open_o);
  assert_act_arms_rcd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_act && (ld_val[WIN_RCD] != '0)) |=> !win_zero[WIN_RCD]);
  assert_idle_reason_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (block_reason_o == 3'd0) && !grant_o);
endmodule

// File: tb/dram_cmd_guard_bench.sv
module dram_cmd_guard_bench;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [TW-1:0] trcd = '0, tras = '0, trp = '0, trc = '0, tcl = '0, trwt = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_cmd = 2'd0;
  logic          grant;
  logic [2:0]    reason;
  logic          bank_open;

  int checks = 0;
  int fails  = 0;
  int cyc, act_t, pre_t, rd_t;
  bit m_open;
  bit zero_cfg;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  dram_cmd_guard #(.TW(TW)) u_dram_cmd_guard (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load),
    .cfg_trcd_i(trcd), .cfg_tras_i(tras), .cfg_trp_i(trp), .cfg_trc_i(trc),
    .cfg_tcl_i(tcl), .cfg_trwt_i(trwt),
    .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .grant_o(grant), .block_reason_o(reason), .bank_open_o(bank_open)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // reference rules computed from the requirements
  task automatic expect_for(input bit v, input logic [1:0] c,
                            output bit eg, output int er);
    int rc_eff;
    rc_eff = imax(int'(trc), int'(tras) + int'(trp));
    eg = 1'b0; er = 0;
    if (!v) return;
    case (c)
      2'd0: if (m_open) er = 1;
            else if (cyc < pre_t + int'(trp)) er = 4;
            else if (cyc < act_t + rc_eff) er = 5;
            else eg = 1'b1;
      2'd1: if (!m_open) er = 1;
            else if (cyc < act_t + int'(trcd)) er = 2;
            else eg = 1'b1;
      2'd2: if (!m_open) er = 1;
            else if (cyc < act_t + int'(trcd)) er = 2;
            else if (cyc < rd_t + int'(tcl) + 1 + int'(trwt)) er = 6;
            else eg = 1'b1;
      default: if (!m_open) er = 1;
            else if (cyc < act_t + int'(tras)) er = 3;
            else eg = 1'b1;
    endcase
  endtask

  task automatic step(input bit v, input logic [1:0] c, output bit granted);
    bit eg; int er; string tag;
    @(negedge clk);
    req_valid = v; req_cmd = c;
    #5;
    expect_for(v, c, eg, er);
    case (er)
      1: tag = "R2"; 2: tag = "R3"; 3: tag = "R4";
      4: tag = "R5"; 5: tag = "R6"; 6: tag = "R7";
      default: tag = zero_cfg ? "R10" : "R8";
    endcase
    chk(tag, int'(grant), int'(eg));
    chk("R9", int'(reason), er);
    chk("R2", int'(bank_open), int'(m_open));
    @(posedge clk);
    if (eg) begin
      case (c)
        2'd0: begin act_t = cyc; m_open = 1'b1; end
        2'd1: rd_t = cyc;
        2'd3: begin pre_t = cyc; m_open = 1'b0; end
        default: ;
      endcase
    end
    cyc++;
    granted = eg;
  endtask

  task automatic start_cfg(input int a, input int b, input int p, input int r,
                           input int l, input int w);
    bit eg; int er;
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; cfg_load = 1'b0;
    #5;
    chk("R1", int'(bank_open), 0);
    chk("R1", int'(grant), 0);
    @(negedge clk);
    rst_n = 1'b1;
    trcd = TW'(a); tras = TW'(b); trp = TW'(p); trc = TW'(r); tcl = TW'(l); trwt = TW'(w);
    cfg_load = 1'b1;
    zero_cfg = (a + b + p + r + l + w) == 0;
    @(posedge clk);
    #1 cfg_load = 1'b0;
    cyc = 0; act_t = -1000; pre_t = -1000; rd_t = -1000; m_open = 1'b0;
    // reset state: activate grantable at once
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'd0;
    #5;
    expect_for(1'b1, 2'd0, eg, er);
    chk("R1", int'(grant), 1);
    chk("R1", int'(eg), 1);
    req_valid = 1'b0;
  endtask

  task automatic run_cfg(input int a, input int b, input int p, input int r,
                         input int l, input int w);
    bit g;
    start_cfg(a, b, p, r, l, w);
    for (int round = 0; round < 3; round++) begin
      for (int k = 0; k < 4; k++) begin
        for (int tries = 0; tries < 40; tries++) begin
          step(1'b1, 2'(k), g);
          if (g) break;
        end
        if ((round == 1) && (k == 1)) step(1'b0, 2'd0, g);
      end
    end
    for (int n = 0; n < 120; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[3:2], g);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    run_cfg(0, 0, 0, 0, 0, 0);
    run_cfg(3, 4, 2, 12, 2, 1);   // tRC dominates
    run_cfg(2, 5, 3, 2, 3, 2);    // tRAS+tRP dominates
    run_cfg(1, 1, 1, 1, 1, 0);
    for (int i = 0; i < 24; i++)
      run_cfg(i % 4, 1 + (i / 2) % 4, i % 3, (i * 5) % 9, 1 + i % 3, (i / 3) % 3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule